// File: doc/BRIEF.md
# Memory Array Summation Controller

This block adds up a fixed-length array of unsigned words held in an external synchronous memory. A one-cycle `start` pulse makes it clear its running total and its element index. It then steps through the array one word at a time. For each word it tests the index, drives a read request at the base address plus the index, adds the returned word to the total, and advances the index. When the index reaches the array length, it raises `done` and presents the total on `sum` until the next start.

The controller is a small state machine with distinct clear, test, fetch, accumulate and step states. The datapath holds a total register and an index register, each loaded either with zero or with an arithmetic result. A parameter selects how that arithmetic is built. One option uses a dedicated adder for the total and a dedicated incrementer for the index. The other uses one adder whose operands are switched between (total, read word) and (index, one) by the current state. Both options give the same results in the same cycles.

Top module: `array_sum_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `mem_rd` are 0 and `sum` is 0.
- R2: After a run, `sum` equals the unsigned sum of the NUM_ELEMS (128) words read. The total is ELEM_W + log2(NUM_ELEMS) bits wide, so it does not wrap even when every word is all ones.
- R3: Each run issues exactly NUM_ELEMS read strobes. The k-th strobe (k = 0, 1, ...) carries address `base_addr + k`, truncated to ADDR_W bits. Each strobe lasts one cycle and two strobes are never on adjacent cycles.
- R4: The memory returns the word in the cycle after the strobe, and it is only valid in that cycle. The block adds the word it sees in that cycle and no other.
- R5: `done` rises 4*NUM_ELEMS+2 (514) clock edges after the edge that samples `start`.
- R6: Once `done` is high, it stays high, `sum` holds its value and `mem_rd` stays 0, until `start` is sampled.
- R7: A `start` pulse during a run is ignored. The run finishes with the same sum and the same latency.
- R8: A `start` sampled while `done` is high begins a new run. `done` is 0 in the next cycle, and `sum` is 0 in the cycle after that.
- R9: The shared-adder variant (SHARED_ADDER=1) gives the same `sum`, and the same `done` timing, as the separate-adder variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a summation |
| base_addr | input | ADDR_W | Address of array element 0, held stable during a run |
| mem_addr | output | ADDR_W | Read address, base plus current index |
| mem_rd | output | 1 | Read strobe, one cycle per element |
| mem_rdata | input | ELEM_W | Word returned by the memory one cycle after the strobe |
| sum | output | SUM_W | Running total, final result while done is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
The array is filled with four data patterns:
- an address-dependent ramp, which exposes a wrong index or address offset;
- all ones, which exposes a total that is too narrow;
- all zeros;
- alternating 0x5555/0xAAAA, placed so that the last element sits at the top address, which exposes an off-by-one in the loop bound.

The memory model drives a poison word in every cycle except the one after a strobe, so capturing the read word in the wrong cycle shows up in the sum. Runs are started from idle, from the done state, and with an extra start pulse in the middle of a run. Both adder variants run side by side on identical stimulus so that their sums and done timing can be compared.

// File: rtl/asum_pkg.sv
// Package: shared state encoding for the array summation controller.
// Assumes: consumers compare against the enum names, never raw codes.
package asum_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_TEST,
        ST_FETCH,
        ST_ACCUM,
        ST_STEP,
        ST_FINISH
    } asum_state_e;
endpackage

// File: rtl/asum_ctrl.sv
// Module: asum_ctrl
// Sequencer for the summation loop: clear, then repeat test/fetch/accumulate/step
// until the index test fails, then hold in a finished state.
// Assumes: idx_more is a registered-state compare from the datapath; start is
// honoured only from the idle and finished states.
module asum_ctrl
    import asum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idx_more,
    output logic clr,
    output logic acc_en,
    output logic idx_en,
    output logic mem_rd,
    output logic done
);
    asum_state_e state_q, state_d;

    // State register, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_TEST;
            ST_TEST:   state_d = idx_more ? ST_FETCH : ST_FINISH;
            ST_FETCH:  state_d = ST_ACCUM;
            ST_ACCUM:  state_d = ST_STEP;
            ST_STEP:   state_d = ST_TEST;
            ST_FINISH: if (start) state_d = ST_CLEAR;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Control outputs, one per state.
    always_comb begin
        clr    = (state_q == ST_CLEAR);
        acc_en = (state_q == ST_ACCUM);
        idx_en = (state_q == ST_STEP);
        mem_rd = (state_q == ST_FETCH);
        done   = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/asum_datapath.sv
// Module: asum_datapath
// Total and index registers, each loaded with zero or an arithmetic result,
// plus address formation. SHARED_ADDER picks one time-shared adder or two units.
// Assumes: acc_en and idx_en are never high together; IDX_W < ADDR_W; IDX_W <= SUM_W.
module asum_datapath #(
    parameter int ELEM_W       = 16,
    parameter int ADDR_W       = 10,
    parameter int NUM_ELEMS    = 128,
    parameter int SUM_W        = 23,
    parameter int IDX_W        = 8,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic              idx_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              idx_more,
    output logic [SUM_W-1:0]  acc
);
    localparam int ADDR_PAD = ADDR_W - IDX_W;
    localparam int DATA_PAD = SUM_W - ELEM_W;
    localparam int IDXS_PAD = SUM_W - IDX_W;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_ELEMS);

    logic [SUM_W-1:0] acc_q, acc_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [SUM_W-1:0] op_a, op_b, res;
            logic             unused_hi;
            // Operand steering: total+word in accumulate, index+1 otherwise.
            always_comb begin
                if (acc_en) begin
                    op_a = acc_q;
                    op_b = {{DATA_PAD{1'b0}}, mem_rdata};
                end else begin
                    op_a = {{IDXS_PAD{1'b0}}, idx_q};
                    op_b = SUM_W'(1);
                end
                res   = op_a + op_b;
                acc_d = res;
                idx_d = res[IDX_W-1:0];
            end
            assign unused_hi = ^res[SUM_W-1:IDX_W];
        end else begin : g_split
            // Dedicated adder and incrementer.
            always_comb begin
                acc_d = acc_q + {{DATA_PAD{1'b0}}, mem_rdata};
                idx_d = idx_q + IDX_W'(1);
            end
        end
    endgenerate

    // Register update: zero on clear, else the arithmetic result when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            idx_q <= '0;
        end else begin
            if (acc_en) acc_q <= acc_d;
            if (idx_en) idx_q <= idx_d;
        end
    end

    // Address, loop test and result outputs.
    always_comb begin
        mem_addr = base_addr + {{ADDR_PAD{1'b0}}, idx_q};
        idx_more = (idx_q < LIMIT);
        acc      = acc_q;
    end
endmodule

// File: rtl/array_sum_engine.sv
// Module: array_sum_engine (top)
// Sums NUM_ELEMS unsigned words read from a synchronous memory with one-cycle
// read latency, starting at base_addr; raises done and holds the total.
// Assumes: base_addr stable during a run; memory data valid the cycle after mem_rd.
module array_sum_engine #(
    parameter int ELEM_W       = 16,
    parameter int ADDR_W       = 10,
    parameter int NUM_ELEMS    = 128,
    parameter bit SHARED_ADDER = 1'b0,
    localparam int IDX_W       = $clog2(NUM_ELEMS + 1),
    localparam int SUM_W       = ELEM_W + $clog2(NUM_ELEMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic [SUM_W-1:0]  sum,
    output logic              done
);
    logic clr, acc_en, idx_en, idx_more;

    asum_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .idx_more(idx_more),
        .clr     (clr),
        .acc_en  (acc_en),
        .idx_en  (idx_en),
        .mem_rd  (mem_rd),
        .done    (done)
    );

    asum_datapath #(
        .ELEM_W      (ELEM_W),
        .ADDR_W      (ADDR_W),
        .NUM_ELEMS   (NUM_ELEMS),
        .SUM_W       (SUM_W),
        .IDX_W       (IDX_W),
        .SHARED_ADDER(SHARED_ADDER)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .acc_en   (acc_en),
        .idx_en   (idx_en),
        .base_addr(base_addr),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .idx_more (idx_more),
        .acc      (sum)
    );
endmodule

// File: rtl/asum_chk.sv
// Module: asum_chk
// Protocol checks on the summation controller's ports, bound into the top.
// Assumes: observes ports only; a cycle counter gates the 4-cycle lookback.
module asum_chk #(
    parameter int ADDR_W = 10,
    parameter int SUM_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [SUM_W-1:0]  sum
);
    logic [2:0] warm_q;

    // Saturating count of cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
    end

    // R3
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3
    rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q > 3'd4 && mem_rd && $past(mem_rd, 4)) |-> mem_addr == $past(mem_addr, 4) + ADDR_W'(1));

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != 3'd0 && done && !start) |=> (done && $stable(sum)));

    // R8
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
endmodule

bind array_sum_engine asum_chk #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .mem_rd  (mem_rd),
    .mem_addr(mem_addr),
    .sum     (sum)
);

// File: tb/array_sum_engine_bench.sv
// Scoreboard bench: the driver pushes expected sums, the monitor pops them on done.
module array_sum_engine_bench;
    localparam int ELEM_W = 16;
    localparam int ADDR_W = 10;
    localparam int N      = 128;
    localparam int SUM_W  = ELEM_W + $clog2(N);
    localparam int LAT    = 4 * N + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] addr_a, addr_b;
    logic rd_a, rd_b, done_a, done_b;
    logic [ELEM_W-1:0] rdata_a, rdata_b, word_a_q, word_b_q;
    logic v_a_q = 1'b0, v_b_q = 1'b0;
    logic [SUM_W-1:0] sum_a, sum_b;

    int errors = 0, checks = 0, runs_done = 0, cur_pat = 0;
    int rd_cnt = 0, bad_addr = 0, back2back = 0;
    longint cyc = 0, start_edge = 0;
    logic prev_rd = 1'b0, prev_done = 1'b0;
    logic [SUM_W-1:0] exp_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    array_sum_engine #(.ELEM_W(ELEM_W), .ADDR_W(ADDR_W), .NUM_ELEMS(N), .SHARED_ADDER(1'b0))
    u_array_sum_engine (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_addr(addr_a), .mem_rd(rd_a), .mem_rdata(rdata_a), .sum(sum_a), .done(done_a));

    array_sum_engine #(.ELEM_W(ELEM_W), .ADDR_W(ADDR_W), .NUM_ELEMS(N), .SHARED_ADDER(1'b1))
    u_array_sum_engine_shared (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_addr(addr_b), .mem_rd(rd_b), .mem_rdata(rdata_b), .sum(sum_b), .done(done_b));

    function automatic logic [ELEM_W-1:0] word_of(input int pat, input logic [ADDR_W-1:0] a);
        case (pat)
            0:       return ELEM_W'(int'(a) * 3 + 1);
            1:       return '1;
            2:       return '0;
            default: return a[0] ? 16'h5555 : 16'hAAAA;
        endcase
    endfunction

    // Memory models: word valid only in the cycle after a strobe (R4), poison otherwise.
    always @(posedge clk) begin
        v_a_q <= rd_a;  word_a_q <= word_of(cur_pat, addr_a);
        v_b_q <= rd_b;  word_b_q <= word_of(cur_pat, addr_b);
    end
    assign rdata_a = v_a_q ? word_a_q : 16'hDEAD;
    assign rdata_b = v_b_q ? word_b_q : 16'hDEAD;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: strobe addresses (R3) and scoreboard pop on done (R2, R4, R5, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_a) begin
                if (addr_a != ADDR_W'(base_addr + rd_cnt)) bad_addr++;
                if (prev_rd) back2back++;
                rd_cnt++;
            end
            if (done_a && !prev_done) begin
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected done", 1, 0);
                else begin
                    logic [SUM_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(sum_a == e, "R2/R4 sum", sum_a, e);
                    chk(cyc - start_edge == LAT, "R5 latency", cyc - start_edge, LAT);
                    chk(rd_cnt == N && bad_addr == 0 && back2back == 0, "R3 strobes",
                        rd_cnt * 1000 + bad_addr + back2back, N * 1000);
                    chk(done_b && sum_b == e, "R9 shared variant", sum_b, e);
                end
                runs_done++;
            end
        end
        prev_rd   <= rd_a;
        prev_done <= done_a;
    end

    // Driver: push expectation, pulse start, optionally poke (R7) or check restart (R8).
    task automatic run(input logic [ADDR_W-1:0] base, input int pat, input bit poke, input bit restart);
        logic [SUM_W-1:0] e;
        int target;
        e = '0;
        for (int k = 0; k < N; k++) e += SUM_W'(word_of(pat, ADDR_W'(base + k)));
        exp_q.push_back(e);
        target = runs_done + 1;
        @(negedge clk);
        base_addr = base; cur_pat = pat; rd_cnt = 0; bad_addr = 0; back2back = 0;
        start = 1'b1;
        @(posedge clk); #1 start_edge = cyc;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            chk(done_a == 1'b0, "R8 done drops", done_a, 0);
            @(negedge clk);
            chk(sum_a == '0, "R8 total cleared", sum_a, 0);
        end
        if (poke) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int w = 0; w < 2000; w++) begin
            @(negedge clk); #1;
            if (runs_done == target) break;
        end
        chk(runs_done == target, "R5 run completes", runs_done, target);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!done_a && !rd_a && sum_a == '0, "R1 in reset", {done_a, rd_a} + sum_a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_a && !rd_a && sum_a == '0, "R1 after reset", {done_a, rd_a} + sum_a, 0);

        run(10'd0,   0, 1'b0, 1'b0);   // ramp
        run(10'd37,  1, 1'b0, 1'b0);   // all ones: total width (R2)
        run(10'd896, 3, 1'b0, 1'b0);   // last element at top address

        // R6: hold with done high
        begin
            logic [SUM_W-1:0] held;
            int bad;
            held = sum_a; bad = 0;
            repeat (20) begin
                @(negedge clk);
                if (!done_a || rd_a || sum_a != held) bad++;
            end
            chk(bad == 0, "R6 done hold", bad, 0);
        end

        run(10'd200, 0, 1'b0, 1'b1);   // R8 restart from done
        run(10'd100, 3, 1'b1, 1'b0);   // R7 start during run ignored
        run(10'd5,   2, 1'b0, 1'b0);   // zeros

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule